// File: doc/BRIEF.md
# Power-Management Controller Command Access Port

This block is a single-channel, register-mapped port through which a host reaches a power-management controller over a serial link. The host writes one command word. The block decodes that word into a write flag, a halfword address and sixteen bits of write data. It then hands the command to a serial back end over a request/acknowledge handshake. A four-state machine tracks the transaction until it completes.

A status word is always visible to the host. It holds the state of the machine, the most recent read result, an initialisation-done flag and a sticky error flag.

- **Writes** finish as soon as the back end accepts them.
- **Reads** work differently. Once the back end signals completion, the result is captured and then held. It stays held until the host writes 1 to the valid-clear input, and only then does the port return to idle.
- **Rejected commands** are dropped and recorded in the sticky error flag. A command is rejected if it arrives while a transaction is in flight or before initialisation is done.

Top module: `pwrap_cmd_port`

## Requirements
- R1: After reset the status word is all zeros and the back-end request is low. All zeros means: state idle, no error, no init flag, read data 0.
- R2: The command word is decoded as follows: bit 31 is the write flag (1 = write), bits 30:16 are the halfword address, and bits 15:0 are the write data. An accepted command shows state REQ (code 2) on the next cycle. In that cycle the request is high and the decoded fields are on the back-end outputs.
- R3: A write in REQ returns to IDLE (code 0) the cycle after the back end acknowledges. No valid-clear is needed.
- R4: A read in REQ moves to WFDLE (code 4) on acknowledge. It moves to WFVLDCLR (code 6) on the back end's done pulse, and the back-end read data is captured into status bits 15:0 at that edge.
- R5: While in WFVLDCLR, status bits 15:0 and the state stay unchanged whatever the back end drives, until valid-clear is written.
- R6: A valid-clear write with data bit 1 in WFVLDCLR returns the port to IDLE on the next cycle. A valid-clear write with data 0 has no effect.
- R7: A command written while the state is not IDLE is ignored. The back-end outputs and the state are unaffected, and status bit 22 (error) is set. The error bit stays set until reset.
- R8: Status bit 21 mirrors the init-done input, delayed by one register. While that bit is 0, commands are rejected and set the error bit.
- R9: The request and the decoded command stay stable in REQ until the back end acknowledges.
- R10: The status state field, bits 18:16, only ever holds one of the codes 0, 2, 4 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done_i | input | 1 | Back-end initialisation complete |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_word_i | input | 32 | Command word |
| vldclr_we_i | input | 1 | Valid-clear write strobe |
| vldclr_bit_i | input | 1 | Valid-clear write data (1 releases a read) |
| status_o | output | 32 | Status word |
| be_req_o | output | 1 | Request to the serial back end |
| be_write_o | output | 1 | Request is a write |
| be_addr_o | output | 15 | Halfword address |
| be_wdata_o | output | 16 | Write data |
| be_ack_i | input | 1 | Back end accepted the request |
| be_done_i | input | 1 | Back end finished a read |
| be_rdata_i | input | 16 | Read data from the back end |

## Verification
The assertions run on every cycle. They cover four things:
- the request holding in REQ until acknowledge;
- a write leaving REQ straight to idle;
- the captured read data and state freezing in WFVLDCLR until a clear;
- the error flag setting on a rejected command and staying set, with the state field confined to its four codes.

Other behaviour is only shown by the bench scenarios:
- the bit-exact decode of addresses and data at the field edges;
- the correct read value reaching the status word;
- commands refused before init-done;
- a valid-clear written with 0, or written while not waiting, being ignored.

// File: rtl/pwrap_pkg.sv
package pwrap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_REQ       = 3'd2,
    ST_WAIT_DONE = 3'd4,
    ST_WAIT_CLR  = 3'd6
  } acc_state_e;

  localparam int STATE_W = 3;
endpackage

// File: rtl/pwrap_cmd_decode.sv
module pwrap_cmd_decode
  import pwrap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  localparam int CMD_W = 1 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              fsm_idle_i,
  output logic              accept_o,
  output logic              reject_o,
  output logic              init_q_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int WR_BIT   = CMD_W - 1;
  localparam int ADDR_LSB = DATA_W;

  logic              init_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) init_q <= 1'b0;
    else     init_q <= init_done_i;
  end

  assign accept_o = cmd_we_i & init_q & fsm_idle_i;
  assign reject_o = cmd_we_i & ~accept_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept_o) begin
      wr_q   <= cmd_word_i[WR_BIT];
      addr_q <= cmd_word_i[ADDR_LSB +: ADDR_W];
      data_q <= cmd_word_i[DATA_W-1:0];
    end
  end

  assign init_q_o = init_q;
  assign wr_o     = wr_q;
  assign addr_o   = addr_q;
  assign data_o   = data_q;

  // R9 / R7: a busy port keeps the latched command untouched
  assert_cmd_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!fsm_idle_i) |=> ($stable(addr_q) && $stable(data_q) && $stable(wr_q)));
endmodule

// File: rtl/pwrap_access_fsm.sv
module pwrap_access_fsm
  import pwrap_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept_i,
  input  logic               wr_i,
  input  logic               clr_i,
  input  logic               be_ack_i,
  input  logic               be_done_i,
  input  logic [DATA_W-1:0]  be_rdata_i,
  output logic [STATE_W-1:0] state_o,
  output logic               idle_o,
  output logic               req_o,
  output logic [DATA_W-1:0]  rdata_o
);
  acc_state_e        state_q, state_d;
  logic [DATA_W-1:0] rdata_q;
  logic              capture;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (accept_i) state_d = ST_REQ;
      ST_REQ:       if (be_ack_i) state_d = wr_i ? ST_IDLE : ST_WAIT_DONE;
      ST_WAIT_DONE: if (be_done_i) begin
                      state_d = ST_WAIT_CLR;
                      capture = 1'b1;
                    end
      ST_WAIT_CLR:  if (clr_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (capture) rdata_q <= be_rdata_i;
    end
  end

  assign state_o = state_q;
  assign idle_o  = (state_q == ST_IDLE);
  assign req_o   = (state_q == ST_REQ);
  assign rdata_o = rdata_q;

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && !be_ack_i) |=> (state_q == ST_REQ));
  assert_write_done_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REQ && be_ack_i && wr_i) |=> (state_q == ST_IDLE));
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_CLR && !clr_i) |=> ($stable(rdata_q) && state_q == ST_WAIT_CLR));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !accept_i) |=> (state_q == ST_IDLE));
  assert_state_legal_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {ST_IDLE, ST_REQ, ST_WAIT_DONE, ST_WAIT_CLR}));
endmodule

// File: rtl/pwrap_status_reg.sv
module pwrap_status_reg
  import pwrap_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int STAT_W   = DATA_W + 16,
  localparam int ST_LSB   = DATA_W,
  localparam int INIT_BIT = DATA_W + 5,
  localparam int ERR_BIT  = DATA_W + 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reject_i,
  input  logic               init_q_i,
  input  logic [STATE_W-1:0] state_i,
  input  logic [DATA_W-1:0]  rdata_i,
  output logic [STAT_W-1:0]  status_o
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst)           err_q <= 1'b0;
    else if (reject_i) err_q <= 1'b1;
  end

  always_comb begin
    status_o                     = '0;
    status_o[DATA_W-1:0]         = rdata_i;
    status_o[ST_LSB +: STATE_W]  = state_i;
    status_o[INIT_BIT]           = init_q_i;
    status_o[ERR_BIT]            = err_q;
  end

  assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
    reject_i |=> err_q);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: rtl/pwrap_cmd_port.sv
module pwrap_cmd_port
  import pwrap_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  localparam int CMD_W  = 1 + ADDR_W + DATA_W,
  localparam int STAT_W = DATA_W + 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              vldclr_we_i,
  input  logic              vldclr_bit_i,
  output logic [STAT_W-1:0] status_o,
  output logic              be_req_o,
  output logic              be_write_o,
  output logic [ADDR_W-1:0] be_addr_o,
  output logic [DATA_W-1:0] be_wdata_o,
  input  logic              be_ack_i,
  input  logic              be_done_i,
  input  logic [DATA_W-1:0] be_rdata_i
);
  logic               accept, reject, init_q, idle, wr;
  logic [STATE_W-1:0] state;
  logic [DATA_W-1:0]  rdata;
  logic               clr;

  assign clr = vldclr_we_i & vldclr_bit_i;

  pwrap_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
    .clk(clk), .rst(rst), .init_done_i(init_done_i),
    .cmd_we_i(cmd_we_i), .cmd_word_i(cmd_word_i), .fsm_idle_i(idle),
    .accept_o(accept), .reject_o(reject), .init_q_o(init_q),
    .wr_o(wr), .addr_o(be_addr_o), .data_o(be_wdata_o)
  );

  pwrap_access_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .accept_i(accept), .wr_i(wr), .clr_i(clr),
    .be_ack_i(be_ack_i), .be_done_i(be_done_i), .be_rdata_i(be_rdata_i),
    .state_o(state), .idle_o(idle), .req_o(be_req_o), .rdata_o(rdata)
  );

  pwrap_status_reg #(.DATA_W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .reject_i(reject), .init_q_i(init_q),
    .state_i(state), .rdata_i(rdata), .status_o(status_o)
  );

  assign be_write_o = wr;
endmodule

// File: tb/pwrap_cmd_port_tb.sv
module pwrap_cmd_port_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        init_done_i = 0;
  logic        cmd_we_i = 0;
  logic [31:0] cmd_word_i = '0;
  logic        vldclr_we_i = 0;
  logic        vldclr_bit_i = 0;
  logic [31:0] status_o;
  logic        be_req_o, be_write_o;
  logic [14:0] be_addr_o;
  logic [15:0] be_wdata_o;
  logic        be_ack_i = 0, be_done_i = 0;
  logic [15:0] be_rdata_i = '0;

  int checks = 0, errors = 0;
  bit fin = 0;
  int ack_dly = 0, done_dly = 0;
  logic [15:0] rd_q[$];
  logic [31:0] wr_q[$];

  always #2 clk = ~clk;

  pwrap_cmd_port u_dut (.*);

  function automatic logic [15:0] bmod(input logic [14:0] a);
    return {a[7:0], a[14:7]} ^ 16'h3C5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // back-end model and write scoreboard
  int bst = 0, bcnt = 0;
  logic [14:0] baddr;
  always @(negedge clk) begin
    be_ack_i = 0; be_done_i = 0;
    case (bst)
      0: if (be_req_o) begin bcnt = ack_dly; bst = 1; end
      1: if (bcnt == 0) begin
           be_ack_i = 1; baddr = be_addr_o;
           if (be_write_o) begin
             logic [31:0] e;
             e = (wr_q.size() != 0) ? wr_q.pop_front() : 32'hFFFF_FFFF;
             chk({be_write_o, be_addr_o, be_wdata_o} == e, "R2 write fields",
                 {be_write_o, be_addr_o, be_wdata_o}, e);
             bst = 0;
           end else begin bcnt = done_dly; bst = 2; end
         end else bcnt--;
      2: if (bcnt == 0) begin be_done_i = 1; be_rdata_i = bmod(baddr); bst = 3; end
         else bcnt--;
      3: begin be_rdata_i = ~be_rdata_i; bst = 0; end
      default: bst = 0;
    endcase
  end

  // read scoreboard monitor
  logic [2:0] prev_st = 3'd0;
  always @(negedge clk) begin
    if (!rst && status_o[18:16] == 3'd6 && prev_st != 3'd6) begin
      logic [15:0] e;
      e = (rd_q.size() != 0) ? rd_q.pop_front() : 16'hXXXX;
      chk(status_o[15:0] === e, "R4 read data", {16'h0, status_o[15:0]}, {16'h0, e});
    end
    prev_st = status_o[18:16];
  end

  task automatic do_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic host_cmd(input logic [31:0] w);
    @(negedge clk); cmd_we_i = 1; cmd_word_i = w;
    @(negedge clk); cmd_we_i = 0;
  endtask

  task automatic vldclr(input bit b);
    @(negedge clk); vldclr_we_i = 1; vldclr_bit_i = b;
    @(negedge clk); vldclr_we_i = 0;
  endtask

  task automatic wait_state(input logic [2:0] s, input string tag);
    int n = 0;
    while (status_o[18:16] != s && n < 200) begin @(negedge clk); n++; end
    chk(status_o[18:16] == s, tag, {29'h0, status_o[18:16]}, {29'h0, s});
  endtask

  task automatic do_read(input logic [14:0] a);
    rd_q.push_back(bmod(a));
    host_cmd({1'b0, a, 16'h0});
    wait_state(3'd6, "R4 reach WFVLDCLR");
    vldclr(1);
    chk(status_o[18:16] == 3'd0, "R6 clear to idle", {29'h0, status_o[18:16]}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(status_o == 32'h0, "R1 reset status", status_o, 32'h0);
    chk(be_req_o == 0, "R1 reset req", {31'h0, be_req_o}, 32'h0);

    // R8: rejected before init
    host_cmd({1'b1, 15'h0011, 16'h2222});
    @(negedge clk);
    chk(status_o[18:16] == 3'd0 && !be_req_o, "R8 no start uninit", status_o, 32'h0040_0000);
    chk(status_o[22] == 1, "R8 error set", status_o, 32'h0040_0000);
    do_reset();
    init_done_i = 1;
    repeat (2) @(negedge clk);
    chk(status_o == 32'h0020_0000, "R8 init flag", status_o, 32'h0020_0000);

    // R2/R3 write
    ack_dly = 0;
    wr_q.push_back({1'b1, 15'h1234, 16'hBEEF});
    host_cmd({1'b1, 15'h1234, 16'hBEEF});
    chk(status_o[18:16] == 3'd2 && be_req_o, "R2 REQ state", status_o, 32'h0022_0000);
    chk(be_addr_o == 15'h1234 && be_wdata_o == 16'hBEEF && be_write_o, "R2 decode",
        {be_write_o, be_addr_o, be_wdata_o}, {1'b1, 15'h1234, 16'hBEEF});
    repeat (2) @(negedge clk);
    chk(status_o[18:16] == 3'd0 && !status_o[22], "R3 write idle", status_o, 32'h0020_0000);

    // R4/R5/R6/R7 read
    ack_dly = 2; done_dly = 3;
    rd_q.push_back(bmod(15'h0042));
    host_cmd({1'b0, 15'h0042, 16'h0});
    chk(status_o[18:16] == 3'd2 && !be_write_o, "R2 read REQ", status_o, 32'h0022_0000);
    wait_state(3'd4, "R4 WFDLE");
    wait_state(3'd6, "R4 WFVLDCLR");
    repeat (5) @(negedge clk);
    chk(status_o[15:0] == bmod(15'h0042) && status_o[18:16] == 3'd6, "R5 data held",
        status_o, {16'h0026, bmod(15'h0042)});
    vldclr(0);
    chk(status_o[18:16] == 3'd6, "R6 clear with 0 ignored", {29'h0, status_o[18:16]}, 32'h6);
    host_cmd({1'b1, 15'h7777, 16'h5555});
    chk(status_o[18:16] == 3'd6 && status_o[22] && !be_req_o, "R7 busy cmd ignored",
        status_o, {16'h0066, bmod(15'h0042)});
    vldclr(1);
    chk(status_o[18:16] == 3'd0, "R6 clear to idle", {29'h0, status_o[18:16]}, 32'h0);
    chk(status_o[22] == 1, "R7 error sticky", status_o, 32'h0060_0000);
    vldclr(1);
    chk(status_o[18:16] == 3'd0 && !be_req_o, "R6 clear in idle ignored", status_o, 32'h0060_0000);

    // R9 stalled request with a competing command
    ack_dly = 6;
    wr_q.push_back({1'b1, 15'h0001, 16'h00A5});
    host_cmd({1'b1, 15'h0001, 16'h00A5});
    host_cmd({1'b0, 15'h7F00, 16'hFFFF});
    chk(be_req_o && be_addr_o == 15'h0001 && be_wdata_o == 16'h00A5 && be_write_o,
        "R9 request held", {be_write_o, be_addr_o, be_wdata_o}, {1'b1, 15'h0001, 16'h00A5});
    wait_state(3'd0, "R3 stalled write idle");

    // R4 scoreboarded reads at field edges
    ack_dly = 0; done_dly = 0;
    do_read(15'h7FFF);
    do_read(15'h0000);
    ack_dly = 3; done_dly = 1;
    do_read(15'h2AAA);
    do_read(15'h5555);
    chk(rd_q.size() == 0 && wr_q.size() == 0, "R4 scoreboard drained",
        rd_q.size() + wr_q.size(), 0);

    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule